// File: doc/BRIEF.md
# Oversampled Reply Run-Length Decoder

This block recovers the raw reply word that a motor controller sends back on one of several shared lines after a command frame. The reply has already been captured as a buffer of samples. Each buffer entry holds one sample of every lane, and the sample rate is a known non-integer multiple of the reply bit rate. After a start pulse the block fetches the buffer entries in ascending order through a read port with one cycle of latency. It takes the bit of the chosen lane and inverts it, so that a low line level stands for a logic one.

The block does not recover a clock. It measures how long the line stays at each level. At every level change it turns the length of the run that just ended into a whole number of bits and appends that many copies of the run's level to the reply. The conversion rounds with a threshold biased towards longer runs, so that pulses shortened by slow edges still decode. The idle stretch before the first level change is thrown away. Collection stops once the reply register is full. A reply that ends early is padded with zeros at its low end. On completion the block raises a valid flag and reports the reply together with the number of bits that were actually observed. Decoding of the line code, the checksum and the speed value happens in later logic.

Top module: `rl_reply_decoder`

## Requirements
- R1: The lane chosen by `lane_sel_i` is captured when a start is accepted. Each sample of that lane is inverted before use, so a line level of 0 counts as bit value 1. The first bit taken into the reply ends up in bit 20 and later bits follow towards bit 0.
- R2: The samples up to and including the first level change only arm the bit collection. A level change is a difference between the inverted sample and the previous level, which starts at 0 after every start. The run before the first change adds no bits.
- R3: A run of L samples that ends at a level change adds floor((L*100 + 319) / 533) bits of the run's level. The ratio 533 is the sample rate over the bit rate times 100, and 319 is 60 percent of it. So L=7 gives 1 bit, L=8 gives 2 bits, L=13 gives 3 bits and L=16 gives 3 bits.
- R4: A run that rounds to zero bits (L of 1 or 2 with the default ratio) still adds exactly one bit.
- R5: A run still open when the buffer ends, which no level change has closed, adds no bits.
- R6: Collection stops once 21 bits have been gathered. If a run would add more bits than remain, the excess is dropped. Samples after the stopping point have no effect on the result.
- R7: When fewer than 21 bits are gathered, the reported reply is the gathered bits shifted left by 21 minus the count, with zeros below them.
- R8: `bit_count_o` reports the number of bits actually gathered, from 0 to 21.
- R9: `valid_o` is low after reset and from an accepted start until completion. When the whole buffer is scanned it rises exactly DEPTH+2 cycles after the start edge, and never later than that. It then holds, along with the reply and count, until the next accepted start.
- R10: A start pulse during a decode, and any change of `lane_sel_i` after the start has been accepted, leave the running decode and its result unchanged.
- R11: Reads are issued one per cycle at ascending addresses from 0 and never beyond DEPTH-1. No read is issued outside a decode. `rd_data_i` is used one cycle after its address is presented.
- R12: After reset `valid_o` and `rd_en_o` are 0, and `reply_o` and `bit_count_o` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a decode when the block is idle |
| lane_sel_i | input | SEL_W (3) | Lane to decode, captured at start |
| rd_en_o | output | 1 | Sample buffer read request |
| rd_addr_o | output | ADDR_W (8) | Sample buffer read address |
| rd_data_i | input | LANES (8) | One sample of every lane, valid the cycle after the request |
| reply_o | output | REPLY_BITS (21) | Recovered reply, first bit in the top position, zero-padded |
| valid_o | output | 1 | Result ready; held until the next start |
| bit_count_o | output | CNT_W (5) | Number of bits actually observed |

## Verification
The bench builds the block with a 128-entry buffer, eight lanes and the default ratio of 533 with a bias of 319. At that depth a clean 21-bit reply after a random idle stretch sometimes fills the register before the buffer ends and sometimes runs past the end. This brings both the early stop and the zero-padded short reply within reach in random runs. Directed buffers place run lengths on either side of the rounding points (1, 7, 8, 13, 16 and an overlong run). The bench also compares results whose samples differ only after the stop point, and it disturbs the start and lane inputs during a decode.

// File: rtl/rl_reply_pkg.sv
package rl_reply_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_FINISH = 2'd2
  } rl_state_e;

  // Fixed-point scale used for the oversampling ratio and the rounding bias.
  localparam int unsigned PCT_SCALE = 100;

  // Samples per reply bit, times PCT_SCALE. The reply bit lasts num/den of a
  // transmit bit, and one sample takes rx_cyc of the tx_cyc clocks of a
  // transmit bit.
  function automatic int unsigned ratio_x100(input int unsigned tx_cyc,
                                             input int unsigned rx_cyc,
                                             input int unsigned num,
                                             input int unsigned den);
    return ((tx_cyc * PCT_SCALE * num) / den) / rx_cyc;
  endfunction

  // Rounding offset for the run-length conversion, as a share of the ratio.
  function automatic int unsigned bias_x100(input int unsigned ratio,
                                            input int unsigned pct);
    return (ratio * pct) / PCT_SCALE;
  endfunction

endpackage

// File: rtl/rl_sample_fetch.sv
// Issues ascending reads into the sample buffer and marks the cycle in which
// the returned sample is present (one cycle after the request).
module rl_sample_fetch #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              halt,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              data_ok_o,
  output logic              data_last_o
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic at_end;
  assign at_end = (rd_addr_o == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_o     <= 1'b0;
      rd_addr_o   <= '0;
      data_ok_o   <= 1'b0;
      data_last_o <= 1'b0;
    end else begin
      data_ok_o   <= rd_en_o && !halt && !launch;
      data_last_o <= rd_en_o && at_end && !halt && !launch;
      if (launch) begin
        rd_en_o   <= 1'b1;
        rd_addr_o <= '0;
      end else if (halt) begin
        rd_en_o <= 1'b0;
      end else if (rd_en_o) begin
        if (at_end) begin
          rd_en_o <= 1'b0;
        end else begin
          rd_addr_o <= rd_addr_o + ADDR_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/rl_run_meter.sv
// Tracks the level of the selected lane and measures the current run.
// Instead of dividing the run length at each level change, it keeps the
// quotient and remainder of (L*STEP + BIAS) / OSR up to date one sample at a
// time: STEP < OSR, so at most one subtraction per sample is needed.
module rl_run_meter #(
  parameter int unsigned LANES = 8,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned OSR   = 533,
  parameter int unsigned BIAS  = 319,
  parameter int unsigned STEP  = 100,
  parameter int unsigned RUN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample_ok,
  input  logic [LANES-1:0] lanes_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             edge_o,
  output logic             last_o,
  output logic [RUN_W-1:0] run_bits_o
);

  localparam int unsigned ACC_W = $clog2(OSR + STEP + 1);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] acc_nx;
  logic [RUN_W-1:0] nb_q;
  logic [RUN_W-1:0] nb_nx;
  logic             last_q;
  logic             level;

  // Inverted line: a low level stands for a one.
  assign level = ~lanes_i[sel_i];

  always_comb begin
    acc_sum = acc_q + ACC_W'(STEP);
    if (acc_sum >= ACC_W'(OSR)) begin
      acc_nx = acc_sum - ACC_W'(OSR);
      nb_nx  = nb_q + RUN_W'(1);
    end else begin
      acc_nx = acc_sum;
      nb_nx  = nb_q;
    end
  end

  assign edge_o     = sample_ok && (level != last_q);
  assign last_o     = last_q;
  // A run too short to round up to a bit still counts as one.
  assign run_bits_o = (nb_nx == '0) ? RUN_W'(1) : nb_nx;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      last_q <= 1'b0;
      acc_q  <= ACC_W'(BIAS);
      nb_q   <= '0;
    end else if (sample_ok) begin
      if (edge_o) begin
        last_q <= level;
        acc_q  <= ACC_W'(BIAS);
        nb_q   <= '0;
      end else begin
        acc_q <= acc_nx;
        nb_q  <= nb_nx;
      end
    end
  end

endmodule

// File: rtl/rl_reply_shift.sv
// Reply register: appends a group of equal bits in one cycle at the low end,
// saturating at REPLY_BITS, and presents the left-aligned, zero-padded word.
module rl_reply_shift #(
  parameter int unsigned REPLY_BITS = 21,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned RUN_W      = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  push,
  input  logic                  push_level,
  input  logic [RUN_W-1:0]      push_bits,
  output logic [REPLY_BITS-1:0] packed_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  full_o
);

  localparam int unsigned WIDE = ((RUN_W > CNT_W) ? RUN_W : CNT_W) + 1;

  logic [REPLY_BITS-1:0] word_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [WIDE-1:0]       room;
  logic [WIDE-1:0]       take;
  logic [REPLY_BITS-1:0] ones_mask;
  logic [REPLY_BITS-1:0] word_nx;

  always_comb begin
    room      = WIDE'(REPLY_BITS) - WIDE'(cnt_q);
    take      = (WIDE'(push_bits) > room) ? room : WIDE'(push_bits);
    ones_mask = ~({REPLY_BITS{1'b1}} << take);
    word_nx   = (word_q << take) | (push_level ? ones_mask : '0);
  end

  assign full_o   = (cnt_q == CNT_W'(REPLY_BITS));
  assign cnt_o    = cnt_q;
  assign packed_o = word_q << (CNT_W'(REPLY_BITS) - cnt_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (push && !full_o) begin
      word_q <= word_nx;
      cnt_q  <= cnt_q + CNT_W'(take);
    end
  end

endmodule

// File: rtl/rl_reply_decoder.sv
module rl_reply_decoder
  import rl_reply_pkg::*;
#(
  parameter int unsigned LANES         = 8,
  parameter int unsigned DEPTH         = 256,
  parameter int unsigned REPLY_BITS    = 21,
  parameter int unsigned TX_BIT_CYC    = 40,
  parameter int unsigned RX_SAMPLE_CYC = 6,
  parameter int unsigned RX_RATE_NUM   = 4,
  parameter int unsigned RX_RATE_DEN   = 5,
  parameter int unsigned BIAS_PCT      = 60,
  parameter int unsigned SEL_W         = (LANES > 1) ? $clog2(LANES) : 1,
  parameter int unsigned ADDR_W        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned CNT_W         = $clog2(REPLY_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [SEL_W-1:0]      lane_sel_i,
  output logic                  rd_en_o,
  output logic [ADDR_W-1:0]     rd_addr_o,
  input  logic [LANES-1:0]      rd_data_i,
  output logic [REPLY_BITS-1:0] reply_o,
  output logic                  valid_o,
  output logic [CNT_W-1:0]      bit_count_o
);

  localparam int unsigned OSR   = ratio_x100(TX_BIT_CYC, RX_SAMPLE_CYC, RX_RATE_NUM, RX_RATE_DEN);
  localparam int unsigned BIAS  = bias_x100(OSR, BIAS_PCT);
  localparam int unsigned STEP  = PCT_SCALE;
  localparam int unsigned RUN_W = $clog2(DEPTH + 1);

  rl_state_e             state_q;
  logic [SEL_W-1:0]      lane_q;
  logic                  armed_q;

  logic                  idle_act;
  logic                  scan_act;
  logic                  launch;
  logic                  halt;
  logic                  scan_done;
  logic                  data_ok;
  logic                  data_last;
  logic                  sample_ok;
  logic                  edge_hit;
  logic                  last_lvl;
  logic [RUN_W-1:0]      run_bits;
  logic                  push;
  logic                  full;
  logic [REPLY_BITS-1:0] packed_word;
  logic [CNT_W-1:0]      cnt;

  assign idle_act  = (state_q == ST_IDLE);
  assign scan_act  = (state_q == ST_SCAN);
  assign launch    = idle_act && start_i;
  assign scan_done = scan_act && (full || (data_ok && data_last));
  assign halt      = scan_done;
  assign sample_ok = scan_act && data_ok && !full;
  assign push      = sample_ok && edge_hit && armed_q;

  rl_sample_fetch #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) fetch_i (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .halt        (halt),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .data_ok_o   (data_ok),
    .data_last_o (data_last)
  );

  rl_run_meter #(
    .LANES (LANES),
    .SEL_W (SEL_W),
    .OSR   (OSR),
    .BIAS  (BIAS),
    .STEP  (STEP),
    .RUN_W (RUN_W)
  ) meter_i (
    .clk        (clk),
    .rst        (rst),
    .clear      (launch),
    .sample_ok  (sample_ok),
    .lanes_i    (rd_data_i),
    .sel_i      (lane_q),
    .edge_o     (edge_hit),
    .last_o     (last_lvl),
    .run_bits_o (run_bits)
  );

  rl_reply_shift #(
    .REPLY_BITS (REPLY_BITS),
    .CNT_W      (CNT_W),
    .RUN_W      (RUN_W)
  ) shift_i (
    .clk        (clk),
    .rst        (rst),
    .clear      (launch),
    .push       (push),
    .push_level (last_lvl),
    .push_bits  (run_bits),
    .packed_o   (packed_word),
    .cnt_o      (cnt),
    .full_o     (full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      lane_q      <= '0;
      armed_q     <= 1'b0;
      valid_o     <= 1'b0;
      reply_o     <= '0;
      bit_count_o <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            lane_q  <= lane_sel_i;
            armed_q <= 1'b0;
            valid_o <= 1'b0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          // The first level change only arms collection; its run is idle.
          if (sample_ok && edge_hit) begin
            armed_q <= 1'b1;
          end
          if (scan_done) begin
            state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          reply_o     <= packed_word;
          bit_count_o <= cnt;
          valid_o     <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/rl_reply_checker.sv
module rl_reply_checker #(
  parameter int unsigned REPLY_BITS = 21,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CNT_W      = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start_i,
  input logic                  rd_en_o,
  input logic [ADDR_W-1:0]     rd_addr_o,
  input logic [REPLY_BITS-1:0] reply_o,
  input logic                  valid_o,
  input logic [CNT_W-1:0]      bit_count_o,
  input logic                  idle_act,
  input logic                  scan_act
);

  // R11: consecutive reads step through ascending addresses
  a_r11_addr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + ADDR_W'(1)));

  // R11: no read request outside a decode
  a_r11_read_in_scan: assert property (@(posedge clk) disable iff (rst)
    !scan_act |-> !rd_en_o);

  // R9: an accepted start drops valid in the next cycle
  a_r9_start_clears_valid: assert property (@(posedge clk) disable iff (rst)
    (idle_act && start_i) |=> !valid_o);

  // R9: valid is only shown while idle
  a_r9_valid_idle: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> idle_act);

  // R9: result holds while valid
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> ($stable(reply_o) && $stable(bit_count_o)));

  // R8: count never exceeds the reply width
  a_r8_count_max: assert property (@(posedge clk) disable iff (rst)
    bit_count_o <= CNT_W'(REPLY_BITS));

  // R7: positions below the observed bits are zero
  a_r7_zero_pad: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((reply_o & ~({REPLY_BITS{1'b1}} << (CNT_W'(REPLY_BITS) - bit_count_o))) == '0));

endmodule

bind rl_reply_decoder rl_reply_checker #(
  .REPLY_BITS (REPLY_BITS),
  .ADDR_W     (ADDR_W),
  .CNT_W      (CNT_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .rd_en_o     (rd_en_o),
  .rd_addr_o   (rd_addr_o),
  .reply_o     (reply_o),
  .valid_o     (valid_o),
  .bit_count_o (bit_count_o),
  .idle_act    (idle_act),
  .scan_act    (scan_act)
);

// File: tb/rl_reply_decoder_tb_top.sv
module rl_reply_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 8;
  localparam int DEPTH      = 128;
  localparam int RB         = 21;
  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int CNT_W      = 5;
  localparam int OSR        = 533;
  localparam int BIAS       = 319;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [2:0]        lane_sel_i = 3'd0;
  logic              rd_en_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [LANES-1:0]  rd_data_i;
  logic [RB-1:0]     reply_o;
  logic              valid_o;
  logic [CNT_W-1:0]  bit_count_o;

  logic [LANES-1:0]  mem [DEPTH];

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rd_en_o) rd_data_i <= mem[rd_addr_o];
  end

  rl_reply_decoder #(
    .LANES (LANES),
    .DEPTH (DEPTH)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .lane_sel_i  (lane_sel_i),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .rd_data_i   (rd_data_i),
    .reply_o     (reply_o),
    .valid_o     (valid_o),
    .bit_count_o (bit_count_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Reference decode computed from the requirements.
  function automatic void model(input int lane, output logic [RB-1:0] rep,
                                output int cnt, output bit early);
    int  len;
    int  bc;
    int  nb;
    bit  last;
    bit  b;
    len = 0; bc = -1; last = 1'b0; rep = '0; early = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      b = ~mem[i][lane];
      len++;
      if (b != last) begin
        nb = (len * 100 + BIAS) / OSR;
        if (nb == 0) nb = 1;
        if (bc < 0) bc = 0;
        else begin
          while (bc < RB && nb > 0) begin
            rep = {rep[RB-2:0], last};
            bc++;
            nb--;
          end
        end
        len  = 0;
        last = b;
      end
      if (bc >= RB) begin
        early = (i < DEPTH - 1);
        break;
      end
    end
    cnt = (bc < 0) ? 0 : bc;
    rep = rep << (RB - cnt);
  endfunction

  task automatic fill_all(input logic [LANES-1:0] v);
    for (int i = 0; i < DEPTH; i++) mem[i] = v;
  endtask

  task automatic set_span(input int lane, input int from, input int len, input bit lvl);
    for (int i = from; i < from + len; i++) if (i < DEPTH) mem[i][lane] = lvl;
  endtask

  // Clean reply waveform: idle high, then 21 bits at 16/3 samples per bit.
  task automatic put_wave(input int lane, input int prefix, input logic [RB-1:0] bits,
                          input int noise);
    int pos;
    for (int s = 0; s < DEPTH; s++) begin
      if (s < prefix) mem[s][lane] = 1'b1;
      else begin
        pos = ((s - prefix) * 3) / 16;
        mem[s][lane] = (pos < RB) ? ~bits[RB-1-pos] : 1'b1;
      end
      if (noise > 0 && $urandom_range(0, noise) == 0) mem[s][lane] = ~mem[s][lane];
    end
  endtask

  // Starts a decode and waits for valid. poke >= 0 disturbs start/lane then.
  task automatic do_run(input int lane, input int poke, output logic [RB-1:0] r,
                        output int c, output int lat, output bit addr_bad, output int nreads);
    addr_bad = 1'b0; nreads = 0; lat = 0;
    @(negedge clk);
    start_i = 1'b1; lane_sel_i = lane[2:0];
    @(negedge clk);
    start_i = 1'b0;
    while (!valid_o && lat < DEPTH + 20) begin
      if (rd_en_o) begin
        if (rd_addr_o != nreads[ADDR_W-1:0] || nreads >= DEPTH) addr_bad = 1'b1;
        nreads++;
      end
      if (lat == poke) begin
        start_i = 1'b1; lane_sel_i = ~lane[2:0];
      end else if (lat == poke + 1) begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    r = reply_o;
    c = bit_count_o;
  endtask

  task automatic run_case(input int lane, input string tag, input int poke);
    logic [RB-1:0] er;
    logic [RB-1:0] ar;
    int ec, ac, lat, nreads;
    bit early, bad;
    model(lane, er, ec, early);
    do_run(lane, poke, ar, ac, lat, bad, nreads);
    check(ar == er, tag, "reply", 32'(ar), 32'(er));
    check(ac == ec, tag, "bit count (R8)", 32'(ac), 32'(ec));
    if (early) check(lat <= DEPTH + 2, "R9", "latency early stop", 32'(lat), 32'(DEPTH + 2));
    else       check(lat == DEPTH + 2, "R9", "latency full scan", 32'(lat), 32'(DEPTH + 2));
    check(!bad && nreads <= DEPTH, "R11", "read sequence", 32'(nreads), 32'(DEPTH));
  endtask

  // Directed case with a literal expectation.
  task automatic lit_case(input int lane, input string tag,
                          input logic [RB-1:0] xr, input int xc);
    logic [RB-1:0] ar;
    int ac, lat, nreads;
    bit bad;
    do_run(lane, -5, ar, ac, lat, bad, nreads);
    check(ar == xr, tag, "reply", 32'(ar), 32'(xr));
    check(ac == xc, tag, "bit count", 32'(ac), 32'(xc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [RB-1:0] r1;
    logic [RB-1:0] r2;
    int c1, c2, lat, nreads;
    bit bad;
    void'($urandom(32'h5EED_0421));
    fill_all('1);

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    check(valid_o == 1'b0, "R12", "valid after reset", 32'(valid_o), 0);
    check(rd_en_o == 1'b0, "R12", "rd_en after reset", 32'(rd_en_o), 0);
    check(reply_o == '0, "R12", "reply after reset", 32'(reply_o), 0);
    check(bit_count_o == '0, "R12", "count after reset", 32'(bit_count_o), 0);

    // R2: idle buffer gives nothing, full-scan latency
    fill_all('1);
    run_case(0, "R2", -5);
    lit_case(0, "R2", '0, 0);

    // R4: one-sample pulse counts as one bit, first bit lands in bit 20 (R1)
    fill_all('1);
    set_span(3, 10, 1, 1'b0);
    lit_case(3, "R4", 21'h100000, 1);
    fill_all('1);
    set_span(3, 10, 2, 1'b0);
    lit_case(3, "R4", 21'h100000, 1);

    // R3: rounding points with the biased offset
    fill_all('1);
    set_span(1, 10, 7, 1'b0);
    lit_case(1, "R3", 21'h100000, 1);
    fill_all('1);
    set_span(1, 10, 8, 1'b0);
    lit_case(1, "R3", 21'h180000, 2);
    fill_all('1);
    set_span(1, 10, 13, 1'b0);
    lit_case(1, "R3", 21'h1C0000, 3);

    // R5: open run at buffer end adds nothing
    fill_all('1);
    set_span(2, 10, DEPTH - 10, 1'b0);
    lit_case(2, "R5", '0, 0);
    // R2: line low from the first sample only arms collection
    fill_all('1);
    set_span(4, 0, DEPTH, 1'b0);
    lit_case(4, "R2", '0, 0);

    // R1/R7: mixed levels, bit order and zero padding (111001 then zeros)
    fill_all('1);
    set_span(5, 5, 16, 1'b0);
    set_span(5, 32, 5, 1'b0);
    lit_case(5, "R7", 21'h1C8000, 6);

    // R6: overlong run is capped at 21 bits
    fill_all('1);
    set_span(6, 2, 120, 1'b0);
    lit_case(6, "R6", 21'h1FFFFF, 21);

    // R6: samples after the stop point have no effect
    fill_all('1);
    for (int k = 0; k < 7; k++) set_span(7, 4 + 16 * k, 16, (k % 2 == 0) ? 1'b0 : 1'b1);
    set_span(7, 116, 1, 1'b1);
    for (int i = 117; i < DEPTH; i++) mem[i][7] = 1'($urandom);
    do_run(7, -5, r1, c1, lat, bad, nreads);
    check(r1 == 21'h1C71C7, "R6", "reply before tail change", 32'(r1), 32'h1C71C7);
    check(lat <= DEPTH + 2, "R9", "early-stop latency", 32'(lat), 32'(DEPTH + 2));
    for (int i = 117; i < DEPTH; i++) mem[i][7] = ~mem[i][7];
    do_run(7, -5, r2, c2, lat, bad, nreads);
    check(r2 == r1 && c2 == c1, "R6", "reply after tail change", 32'(r2), 32'(r1));

    // R1: distinct content per lane selects the right one
    for (int ln = 0; ln < LANES; ln++) put_wave(ln, 3 + ln, 21'(32'h100000 | (32'h3A5 * (ln + 1))), 0);
    for (int ln = 0; ln < LANES; ln += 3) run_case(ln, "R1", -5);

    // R10: start and lane change during a decode are ignored
    run_case(2, "R10", 20);
    run_case(5, "R10", 60);

    // R9: result holds while idle
    @(negedge clk);
    r1 = reply_o;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b1, "R9", "valid holds", 32'(valid_o), 1);
    check(reply_o == r1, "R9", "reply holds", 32'(reply_o), 32'(r1));

    // Random: clean waves with noise, and raw random samples
    for (int it = 0; it < 40; it++) begin
      if (it % 2 == 0) begin
        for (int ln = 0; ln < LANES; ln++)
          put_wave(ln, $urandom_range(0, 24), 21'($urandom) | 21'h100000,
                   (it % 4 == 0) ? 0 : 30);
        run_case($urandom_range(0, LANES - 1), "R3", -5);
      end else begin
        for (int i = 0; i < DEPTH; i++) mem[i] = LANES'($urandom);
        run_case($urandom_range(0, LANES - 1), "R4", -5);
      end
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule